// File: doc/BRIEF.md
# Multi-Lane I2S Capture Engine

This block is the receive side of an I2S link in which the block itself drives the bit clock and the word-select clock. It divides a master audio clock to produce SCK, counts bit slots to produce LRCLK, and samples several serial data lanes in parallel. Each lane carries one stereo pair. The word length is 16 or 24 bits and is chosen by a single select input. Only standard I2S framing is handled, where the most significant bit lags the word-select edge by one bit.

When a full left/right frame has been captured, the samples from every lane go one per master clock cycle into an internal FIFO. The order is lane 0 left, lane 0 right, lane 1 left, and so on. Each sample carries its channel number. The FIFO feeds an AXI4-Stream master. If the FIFO has no room, the block discards the sample and raises a sticky overflow flag. Capture is armed by an enable input and begins on a frame boundary, so the first sample set delivered is always a complete frame.

Top module: `i2s_rx_multilane`

## Requirements
- R1: After reset SCK is low. SCK then toggles every HALF_DIV master clock cycles, so one SCK period is 2*HALF_DIV master clock cycles.
- R2: LRCLK is low (left slot) for 32 SCK periods and then high (right slot) for 32 SCK periods. It changes only at a falling edge of SCK, and a frame begins at an LRCLK falling edge.
- R3: Each lane is sampled on rising SCK edges. The first bit taken in a slot is the MSB, on the second rising edge after the LRCLK transition. The bits that follow arrive MSB first.
- R4: With wlen24=1, a 24-bit word is captured and appears on m_tdata[23:0] unchanged. With wlen24=0, a 16-bit word is captured and appears on m_tdata[23:8], with m_tdata[7:0]=0.
- R5: Serial bits after the selected word length, and the bit during the LRCLK-transition SCK period, have no effect on the captured sample.
- R6: After the right slot of a frame ends, 2*LANES samples are emitted in channel order. m_tid = 2*lane + side, where side is 0 for left and 1 for right.
- R7: With enable high, capture begins only at the first LRCLK falling edge after enable rises, so no partial frame is emitted. When enable is low, the frame in progress is discarded and nothing is emitted.
- R8: m_tvalid is high while the FIFO holds data. While m_tvalid=1 and m_tready=0, m_tvalid, m_tdata and m_tid hold steady.
- R9: A sample that arrives while the FIFO is full is dropped and sets overflow, which stays high until reset. Samples already in the FIFO are delivered intact and in order. Exactly filling the FIFO does not set overflow.
- R10: During and right after reset, m_tvalid=0, overflow=0, sck=0 and lrclk=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master audio clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Arms capture at the next frame boundary |
| wlen24 | input | 1 | Word length select: 1 = 24 bits, 0 = 16 bits |
| sd_in | input | LANES | Serial data lanes |
| sck | output | 1 | Generated bit clock |
| lrclk | output | 1 | Generated word-select clock (low = left) |
| m_tvalid | output | 1 | Stream valid |
| m_tready | input | 1 | Stream ready |
| m_tdata | output | 24 | Captured sample, MSB aligned |
| m_tid | output | $clog2(2*LANES) | Channel number |
| overflow | output | 1 | Sticky FIFO overflow flag |

## Verification
The case that is hardest to reach from the ports is the FIFO boundary. Exactly DEPTH entries must leave overflow clear, while the next burst must set it and leave the stored frames untouched. The bench holds m_tready low across whole frames: after two frames the FIFO holds exactly 16 entries and overflow is checked clear, and after a third frame it is checked set. The bench then drains the FIFO and compares every entry against its own frame-numbered pattern. Because the serial driver follows the generated clocks and encodes a frame counter in every word, misaligned arming or a disable mid-frame shows up as a wrong frame number or an unexpected output.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;
  localparam int SAMPLE_W  = 24;
  localparam int SLOT_BITS = 32;

  // number of data bits taken per slot
  function automatic logic [4:0] word_len(input logic w24);
    return w24 ? 5'd24 : 5'd16;
  endfunction

  // slot position 0 carries the previous word's tail; data fills 1..len
  function automatic logic in_window(input logic [4:0] pos, input logic w24);
    return (pos != 5'd0) && (pos <= word_len(w24));
  endfunction

  // shifted-in bits sit at the bottom; place them MSB-aligned on 24 bits
  function automatic logic [SAMPLE_W-1:0] align_sample(input logic [SAMPLE_W-1:0] raw,
                                                       input logic w24);
    return w24 ? raw : {raw[15:0], 8'h00};
  endfunction
endpackage

// File: rtl/i2s_rx_clkgen.sv
module i2s_rx_clkgen #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst,
  output logic       sck,
  output logic       lrclk,
  output logic       rise_evt,
  output logic       frame_wrap,
  output logic [4:0] slot_pos,
  output logic       slot_side
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [DIV_W-1:0] div_cnt;
  logic [5:0]       bit_cnt;
  logic             tick;
  logic             fall_evt;
  logic [5:0]       bit_nxt;

  assign tick       = (div_cnt == DIV_W'(HALF_DIV - 1));
  assign rise_evt   = tick & ~sck;
  assign fall_evt   = tick & sck;
  assign frame_wrap = fall_evt & (bit_cnt == 6'd63);
  assign bit_nxt    = bit_cnt + 6'd1;
  assign slot_pos   = bit_cnt[4:0];
  assign slot_side  = bit_cnt[5];

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      sck     <= 1'b0;
      lrclk   <= 1'b0;
      bit_cnt <= '0;
    end else if (tick) begin
      div_cnt <= '0;
      sck     <= ~sck;
      if (sck) begin
        bit_cnt <= bit_nxt;
        lrclk   <= bit_nxt[5];
      end
    end else begin
      div_cnt <= div_cnt + DIV_W'(1);
    end
  end

  // R2
  lrclk_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (lrclk != $past(lrclk)) |-> ($past(sck) && !sck));

  // R2
  side_match_chk: assert property (@(posedge clk) disable iff (rst)
    fall_evt |=> (lrclk == slot_side));
endmodule

// File: rtl/i2s_rx_lane.sv
module i2s_rx_lane
  import i2s_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                rise_evt,
  input  logic [4:0]          slot_pos,
  input  logic                slot_side,
  input  logic                wlen24,
  input  logic                sd,
  output logic [SAMPLE_W-1:0] left_q,
  output logic [SAMPLE_W-1:0] right_q
);
  logic take_bit;

  assign take_bit = rise_evt & in_window(slot_pos, wlen24);

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q  <= '0;
      right_q <= '0;
    end else if (take_bit) begin
      if (slot_side) right_q <= {right_q[SAMPLE_W-2:0], sd};
      else           left_q  <= {left_q[SAMPLE_W-2:0], sd};
    end
  end

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rise_evt |=> ($stable(left_q) && $stable(right_q)));
endmodule

// File: rtl/i2s_rx_fifo.sv
module i2s_rx_fifo #(
  parameter int WIDTH = 27,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [WIDTH-1:0] din,
  output logic             full,
  input  logic             rd,
  output logic [WIDTH-1:0] dout,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [AW:0]      count;
  logic             do_wr, do_rd;

  assign full  = (count == (AW+1)'(DEPTH));
  assign empty = (count == '0);
  assign do_wr = wr & ~full;
  assign do_rd = rd & ~empty;
  assign dout  = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_wr) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + AW'(1);
      if (do_rd) rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + AW'(1);
      count <= count + (AW+1)'(do_wr) - (AW+1)'(do_rd);
    end
  end

  // R9
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= (AW+1)'(DEPTH));

  // R9
  full_block_chk: assert property (@(posedge clk) disable iff (rst)
    (full && !rd) |=> full);
endmodule

// File: rtl/i2s_rx_multilane.sv
module i2s_rx_multilane
  import i2s_rx_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int HALF_DIV   = 2,
  parameter int FIFO_DEPTH = 16,
  localparam int NCH  = 2 * LANES,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                enable,
  input  logic                wlen24,
  input  logic [LANES-1:0]    sd_in,
  output logic                sck,
  output logic                lrclk,
  output logic                m_tvalid,
  input  logic                m_tready,
  output logic [SAMPLE_W-1:0] m_tdata,
  output logic [CH_W-1:0]     m_tid,
  output logic                overflow
);
  localparam int ENTRY_W = SAMPLE_W + CH_W;

  logic                rise_evt, frame_wrap, slot_side;
  logic [4:0]          slot_pos;
  logic [SAMPLE_W-1:0] lane_l [LANES];
  logic [SAMPLE_W-1:0] lane_r [LANES];
  logic [SAMPLE_W-1:0] stage  [NCH];
  logic                armed, busy, emit_start, drop_evt;
  logic [CH_W-1:0]     emit_idx;
  logic                fifo_full, fifo_empty, fifo_wr, fifo_rd;
  logic [ENTRY_W-1:0]  fifo_din, fifo_dout;

  i2s_rx_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk(clk), .rst(rst), .sck(sck), .lrclk(lrclk),
    .rise_evt(rise_evt), .frame_wrap(frame_wrap),
    .slot_pos(slot_pos), .slot_side(slot_side)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    i2s_rx_lane u_lane (
      .clk(clk), .rst(rst), .rise_evt(rise_evt),
      .slot_pos(slot_pos), .slot_side(slot_side), .wlen24(wlen24),
      .sd(sd_in[g]), .left_q(lane_l[g]), .right_q(lane_r[g])
    );
  end

  // arming: a frame is kept only if enable held from its first edge
  always_ff @(posedge clk) begin
    if (rst || !enable) armed <= 1'b0;
    else if (frame_wrap) armed <= 1'b1;
  end

  assign emit_start = frame_wrap & armed & enable;

  always_ff @(posedge clk) begin
    if (emit_start) begin
      for (int i = 0; i < LANES; i++) begin
        stage[2*i]   <= align_sample(lane_l[i], wlen24);
        stage[2*i+1] <= align_sample(lane_r[i], wlen24);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      emit_idx <= '0;
    end else if (emit_start) begin
      busy     <= 1'b1;
      emit_idx <= '0;
    end else if (busy) begin
      if (emit_idx == CH_W'(NCH - 1)) busy <= 1'b0;
      emit_idx <= emit_idx + CH_W'(1);
    end
  end

  assign fifo_din = {emit_idx, stage[emit_idx]};
  assign fifo_wr  = busy & ~fifo_full;
  assign drop_evt = busy & fifo_full;
  assign fifo_rd  = m_tvalid & m_tready;

  always_ff @(posedge clk) begin
    if (rst)           overflow <= 1'b0;
    else if (drop_evt) overflow <= 1'b1;
  end

  i2s_rx_fifo #(.WIDTH(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr(fifo_wr), .din(fifo_din), .full(fifo_full),
    .rd(fifo_rd), .dout(fifo_dout), .empty(fifo_empty)
  );

  assign m_tvalid = ~fifo_empty;
  assign m_tdata  = fifo_dout[SAMPLE_W-1:0];
  assign m_tid    = fifo_dout[ENTRY_W-1:SAMPLE_W];

  // R8
  stream_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tid)));

  // R9
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  // R7
  unarmed_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_wrap && !armed) |=> !busy);

  // R6
  emit_order_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (emit_idx == $past(emit_idx) + CH_W'(1)));
endmodule

// File: tb/tb_i2s_rx_multilane.sv
module tb_i2s_rx_multilane;
  localparam int LANES = 4;
  localparam int HALF  = 2;
  localparam int DEPTH = 16;
  localparam int NCH   = 2 * LANES;
  localparam int CH_W  = $clog2(NCH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic wlen24 = 1'b1;
  logic m_tready = 1'b0;
  logic [LANES-1:0] sd_in = '1;
  logic sck, lrclk, m_tvalid, overflow;
  logic [23:0] m_tdata;
  logic [CH_W-1:0] m_tid;

  int checks = 0;
  int fails = 0;
  int frame_no = 0;
  int ngot = 0;
  logic [23:0] got_d [64];
  int          got_t [64];

  always #10 clk = ~clk;

  i2s_rx_multilane #(.LANES(LANES), .HALF_DIV(HALF), .FIFO_DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .enable(enable), .wlen24(wlen24), .sd_in(sd_in),
    .sck(sck), .lrclk(lrclk), .m_tvalid(m_tvalid), .m_tready(m_tready),
    .m_tdata(m_tdata), .m_tid(m_tid), .overflow(overflow)
  );

  function automatic logic [23:0] pat(input int f, input int ch);
    logic [7:0] fb;
    fb = f[7:0];
    return {fb, 1'b0, 3'(ch), 4'hC, fb ^ 8'(ch * 37)};
  endfunction

  function automatic logic [23:0] expect_word(input int f, input int ch, input logic w24);
    logic [23:0] p;
    p = pat(f, ch);
    return w24 ? p : {p[23:8], 8'h00};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // serial source: follows generated clocks, sends frame-numbered words
  int  pos = 0;
  logic prev_sck = 1'b0, prev_lr = 1'b0;
  always @(negedge clk) begin
    if (rst) begin
      pos = 0; prev_sck = 1'b0; prev_lr = 1'b0; sd_in = '1;
    end else begin
      if (prev_sck && !sck) begin
        if (lrclk != prev_lr) begin
          pos = 0;
          if (!lrclk) frame_no++;
        end else pos++;
        prev_lr = lrclk;
        for (int l = 0; l < LANES; l++) begin
          logic [23:0] w;
          w = pat(frame_no, 2*l + (lrclk ? 1 : 0));
          if (pos >= 1 && pos <= (wlen24 ? 24 : 16)) sd_in[l] = w[24-pos];
          else sd_in[l] = 1'b1;  // junk outside the word (R5)
        end
      end
      prev_sck = sck;
    end
  end

  always @(negedge clk) begin
    if (!rst && m_tvalid && m_tready && ngot < 64) begin
      got_d[ngot] = m_tdata;
      got_t[ngot] = int'(m_tid);
      ngot++;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    @(posedge clk); #2;
    rst = 1'b1; enable = 1'b0; m_tready = 1'b0; wlen24 = 1'b1;
    step(3);
    rst = 1'b0;
    ngot = 0;
  endtask

  // returns the frame number of the first armed frame
  task automatic arm(output int f0);
    int cur;
    enable = 1'b1;
    step(1);
    cur = frame_no;
    while (frame_no == cur) step(1);
    f0 = frame_no;
  endtask

  task automatic wait_frame(input int target);
    while (frame_no < target) step(1);
  endtask

  task automatic t_reset();
    do_reset();
    chk(m_tvalid == 1'b0, "R10 tvalid", 32'(m_tvalid), 0);
    chk(overflow == 1'b0, "R10 overflow", 32'(overflow), 0);
    chk(sck == 1'b0, "R10 sck", 32'(sck), 0);
    chk(lrclk == 1'b0, "R10 lrclk", 32'(lrclk), 0);
  endtask

  task automatic t_clocks();
    int since_rise = 0, last_period = 0, bad_period = 0;
    int rises = 0, seg = 0, bad_seg = 0, bad_align = 0;
    logic ps = 1'b0, pl = 1'b0;
    do_reset();
    for (int c = 0; c < 3 * 64 * 2 * HALF; c++) begin
      @(negedge clk);
      since_rise++;
      if (sck && !ps) begin
        if (last_period > 0 && since_rise != 2 * HALF) bad_period++;
        last_period = since_rise;
        since_rise = 0;
        rises++;
      end
      if (lrclk != pl) begin
        if (!(ps && !sck)) bad_align++;
        if (seg > 0 && rises != 32) bad_seg++;
        seg++;
        rises = 0;
      end
      ps = sck; pl = lrclk;
    end
    chk(bad_period == 0 && last_period == 2 * HALF, "R1 sck period",
        32'(last_period), 32'(2 * HALF));
    chk(bad_seg == 0 && seg >= 4, "R2 slot length", 32'(bad_seg), 0);
    chk(bad_align == 0, "R2 lrclk on sck fall", 32'(bad_align), 0);
  endtask

  task automatic check_stream(input int f0, input int n, input logic w24, input string req);
    for (int i = 0; i < n; i++) begin
      logic [23:0] e;
      e = expect_word(f0 + i / NCH, i % NCH, w24);
      chk(got_d[i] == e, req, 32'(got_d[i]), 32'(e));
      chk(got_t[i] == i % NCH, "R6 tid order", 32'(got_t[i]), 32'(i % NCH));
    end
  endtask

  task automatic t_capture(input logic w24);
    int f0;
    do_reset();
    wlen24 = w24;
    m_tready = 1'b1;
    arm(f0);
    wait_frame(f0 + 3);
    step(20);
    enable = 1'b0;
    step(300);
    chk(ngot == 3 * NCH, "R7 exact frame count", 32'(ngot), 32'(3 * NCH));
    check_stream(f0, 3 * NCH, w24, w24 ? "R3 R4 24-bit data" : "R4 R5 16-bit data");
  endtask

  task automatic t_disable_mid();
    int f0;
    do_reset();
    m_tready = 1'b1;
    arm(f0);
    step(100);
    enable = 1'b0;
    step(700);
    chk(ngot == 0, "R7 disabled frame discarded", 32'(ngot), 0);
    chk(m_tvalid == 1'b0, "R7 no output after disable", 32'(m_tvalid), 0);
  endtask

  task automatic t_overflow();
    int f0;
    logic [23:0] held;
    do_reset();
    m_tready = 1'b0;
    arm(f0);
    wait_frame(f0 + 2);
    step(20);
    chk(overflow == 1'b0, "R9 exact fill no overflow", 32'(overflow), 0);
    wait_frame(f0 + 3);
    step(20);
    enable = 1'b0;
    chk(overflow == 1'b1, "R9 overflow set", 32'(overflow), 1);
    held = m_tdata;
    step(5);
    chk(m_tvalid == 1'b1 && m_tdata == held, "R8 hold under backpressure",
        32'(m_tdata), 32'(held));
    chk(held == expect_word(f0, 0, 1'b1), "R8 head of queue", 32'(held),
        32'(expect_word(f0, 0, 1'b1)));
    m_tready = 1'b1;
    step(60);
    chk(ngot == DEPTH, "R9 retained count", 32'(ngot), 32'(DEPTH));
    check_stream(f0, DEPTH, 1'b1, "R9 retained data");
    chk(overflow == 1'b1, "R9 overflow sticky", 32'(overflow), 1);
  endtask

  initial begin
    #(20 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_clocks();
    t_capture(1'b1);
    t_capture(1'b0);
    t_disable_mid();
    t_overflow();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule